// File: doc/BRIEF.md
# Hierarchical Next-Active-Slot Finder

This block keeps track of which time slots of a calendar-queue scheduler currently hold work, and answers the question "which is the first occupied slot at or after this pointer?" The occupancy is stored as a tree of bitmaps. The bottom level has one bit per slot, packed into words of `FANOUT` bits. Each level above keeps one bit per word of the level beneath it. That bit is set while the word below it is non-zero. With the default `FANOUT = 8` and `LEVELS = 3`, the block covers 512 slots.

A scheduler marks a slot active when it links the first entry into that slot, and marks it inactive when the slot drains. When the calendar pointer has to move on, the scheduler issues a search with the current pointer as its start index. The search first examines the word that holds the start position at every level in parallel. It then walks down the tree one level per cycle from the lowest level that holds a later candidate. If nothing is active at or after the start index, the search wraps to slot 0. Only one operation is in flight at a time, and `req_ready` shows when the next operation can be accepted.

Top module: `hb_next_slot_finder`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` is 0 and every slot is inactive, so a search reports nothing found.
- R2: A request is accepted on a rising edge where both `req_valid` and `req_ready` are 1. From the next cycle `req_ready` stays 0 until that operation has finished.
- R3: An update (`req_write` = 1) makes slot `req_slot` active when `req_active` = 1 and inactive when `req_active` = 0. `req_ready` is 1 again exactly `LEVELS` clock edges after the accepting edge. Repeating an update with the same value leaves the map unchanged.
- R4: For a search (`req_write` = 0), `resp_valid` is high for exactly one cycle, between 1 and `LEVELS` edges after the accepting edge. When an active slot exists at an index greater than or equal to `req_slot`, `resp_found` is 1 and `resp_slot` is the lowest such index.
- R5: When no slot at or above the start index is active but some slot is active, `resp_found` is 1 and `resp_slot` is the lowest active index in the whole map.
- R6: When no slot is active, a search returns `resp_found` = 0 and `resp_slot` = 0.
- R7: While no operation is in progress, every summary bit equals the OR of the word it covers, so every step down the tree finds a set bit.
- R8: Clearing one slot does not hide any other active slot that shares a word or a summary group with it. Clearing the last active slot of a group makes later searches skip that group.
- R9: An active slot equal to the start index is itself returned, and active slots below the start in the same word are passed over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = update a slot, 0 = search |
| req_active | input | 1 | Value written to the slot on an update |
| req_slot | input | LW*LEVELS | Slot to update, or start index of the search |
| resp_valid | output | 1 | One-cycle search result strobe |
| resp_found | output | 1 | An active slot was found |
| resp_slot | output | LW*LEVELS | Slot found, 0 when nothing was found |

## Verification
The hardest case to reach from the ports is a search whose answer does not lie in the start word. In that case every candidate at and below the start position has to be rejected at each level. The search must then climb to an upper level and use a strict greater-than mask there, or wrap and descend from the top. This matters most right after the last active slot of a group was cleared, because the summary bit must have dropped in time. Directed cases build these situations on purpose: slots just below the start in the same word, targets in other top-level groups, and clearing one of two neighbours. Random operations are confined half of the time to a narrow window of 32 slots, so that words and groups fill and empty often. The other half range over all slots, which triggers wrap-around and long descents.

// File: rtl/hb_pkg.sv
package hb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_UPD   = 2'd1,
      ST_PROBE = 2'd2,
      ST_DESC  = 2'd3
   } hb_state_e;
endpackage

// File: rtl/hb_prienc.sv
// Lowest-set-bit encoder that ignores positions below 'from'.
module hb_prienc #(
   parameter int WIDTH = 8,
   parameter int PW    = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] vec,
   input  logic [PW:0]      from,
   output logic             hit,
   output logic [PW-1:0]    pos
);
   if (WIDTH < 2) begin : g_bad_width
      $error("hb_prienc: WIDTH must be at least 2");
   end

   always_comb begin
      hit = 1'b0;
      pos = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i] && (i >= int'(from))) begin
            hit = 1'b1;
            pos = PW'(i);
         end
      end
   end
endmodule

// File: rtl/hb_level.sv
// One level of the occupancy tree: WORDS words of FANOUT bits,
// one bit write port and two word read ports.
module hb_level #(
   parameter int FANOUT = 8,
   parameter int WORDS  = 1,
   parameter int AW     = 9,
   parameter int LW     = $clog2(FANOUT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_bit,
   input  logic              wr_val,
   input  logic [AW-1:0]     rd_a_word,
   output logic [FANOUT-1:0] rd_a_data,
   input  logic [AW-1:0]     rd_b_word,
   output logic [FANOUT-1:0] rd_b_data
);
   if (WORDS < 1) begin : g_bad_words
      $error("hb_level: WORDS must be at least 1");
   end
   if ((1 << LW) != FANOUT) begin : g_bad_fanout
      $error("hb_level: FANOUT must be a power of two");
   end

   logic [FANOUT-1:0] words [WORDS];
   logic [AW-1:0]     wr_word;
   logic [LW-1:0]     wr_pos;

   assign wr_word = wr_bit >> LW;
   assign wr_pos  = wr_bit[LW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) words[w] <= '0;
      end else if (wr_en) begin
         for (int w = 0; w < WORDS; w++) begin
            if (wr_word == AW'(w)) words[w][wr_pos] <= wr_val;
         end
      end
   end

   if (WORDS == 1) begin : g_single
      assign rd_a_data = (rd_a_word == '0) ? words[0] : '0;
      assign rd_b_data = (rd_b_word == '0) ? words[0] : '0;
   end else begin : g_multi
      always_comb begin
         rd_a_data = '0;
         rd_b_data = '0;
         for (int w = 0; w < WORDS; w++) begin
            if (rd_a_word == AW'(w)) rd_a_data = words[w];
            if (rd_b_word == AW'(w)) rd_b_data = words[w];
         end
      end
   end

   // a write never addresses a word beyond this level
   assert_wr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_word < AW'(WORDS)));
endmodule

// File: rtl/hb_next_slot_finder.sv
module hb_next_slot_finder
   import hb_pkg::*;
#(
   parameter int FANOUT = 8,
   parameter int LEVELS = 3,
   localparam int LW     = $clog2(FANOUT),
   localparam int SLOT_W = LW * LEVELS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_active,
   input  logic [SLOT_W-1:0] req_slot,
   output logic              resp_valid,
   output logic              resp_found,
   output logic [SLOT_W-1:0] resp_slot
);
   localparam int LVLW  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam int LATW  = $clog2(LEVELS + 2) + 1;

   if (FANOUT < 2 || (1 << LW) != FANOUT) begin : g_bad_fanout
      $error("hb_next_slot_finder: FANOUT must be a power of two, at least 2");
   end
   if (LEVELS < 1) begin : g_bad_levels
      $error("hb_next_slot_finder: LEVELS must be at least 1");
   end

   hb_state_e         st_q;
   logic              set_q;
   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] idx_q;
   logic [LVLW-1:0]   lvl_q;

   logic [FANOUT-1:0] pa_word [LEVELS];
   logic [FANOUT-1:0] pb_word [LEVELS];
   logic [LEVELS-1:0] pr_hit;
   logic [LW-1:0]     pr_pos  [LEVELS];
   logic [SLOT_W-1:0] pr_cand [LEVELS];

   // ---------------------------------------------------------------
   // tree levels, probe encoders and update write paths
   // ---------------------------------------------------------------
   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int WORDS = FANOUT ** (LEVELS - 1 - l);
      logic              wr_en;
      logic              wr_val;
      logic [SLOT_W-1:0] wr_bit;
      logic [SLOT_W-1:0] a_word;
      logic [LW:0]       from;

      assign wr_bit = slot_q >> (LW * l);
      assign a_word = slot_q >> (LW * (l + 1));
      assign wr_en  = (st_q == ST_UPD) && (lvl_q == LVLW'(l));

      if (l == 0) begin : g_leaf
         assign wr_val = set_q;
         assign from   = {1'b0, wr_bit[LW-1:0]};
      end else begin : g_sum
         assign wr_val = |pa_word[l-1];
         assign from   = {1'b0, wr_bit[LW-1:0]} + 1'b1;

         // a summary bit mirrors the word it covers between operations
         assert_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == ST_IDLE) |-> (pa_word[l][wr_bit[LW-1:0]] == (|pa_word[l-1])));
      end

      hb_level #(
         .FANOUT(FANOUT),
         .WORDS (WORDS),
         .AW    (SLOT_W),
         .LW    (LW)
      ) u_level (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_en),
         .wr_bit   (wr_bit),
         .wr_val   (wr_val),
         .rd_a_word(a_word),
         .rd_a_data(pa_word[l]),
         .rd_b_word(idx_q),
         .rd_b_data(pb_word[l])
      );

      hb_prienc #(.WIDTH(FANOUT), .PW(LW)) u_probe (
         .vec (pa_word[l]),
         .from(from),
         .hit (pr_hit[l]),
         .pos (pr_pos[l])
      );

      assign pr_cand[l] = (a_word << LW) | SLOT_W'(pr_pos[l]);
   end

   // wrap-around candidate: first set bit of the top word
   logic          wrap_hit;
   logic [LW-1:0] wrap_pos;

   hb_prienc #(.WIDTH(FANOUT), .PW(LW)) u_wrap (
      .vec (pa_word[LEVELS-1]),
      .from({(LW + 1){1'b0}}),
      .hit (wrap_hit),
      .pos (wrap_pos)
   );

   // lowest level with a later candidate wins; wrap is the fallback
   logic              sel_any;
   logic [LVLW-1:0]   sel_lvl;
   logic [SLOT_W-1:0] sel_idx;

   always_comb begin
      sel_any = wrap_hit;
      sel_lvl = LVLW'(LEVELS - 1);
      sel_idx = SLOT_W'(wrap_pos);
      for (int l = LEVELS - 1; l >= 0; l--) begin
         if (pr_hit[l]) begin
            sel_any = 1'b1;
            sel_lvl = LVLW'(l);
            sel_idx = pr_cand[l];
         end
      end
   end

   // descent: first set bit of the child word under idx_q
   logic [FANOUT-1:0] d_word;
   logic              d_hit;
   logic [LW-1:0]     d_pos;
   logic [SLOT_W-1:0] d_next;

   always_comb begin
      d_word = '0;
      for (int l = 0; l < LEVELS; l++) begin
         if (int'(lvl_q) == l + 1) d_word = pb_word[l];
      end
   end

   hb_prienc #(.WIDTH(FANOUT), .PW(LW)) u_desc (
      .vec (d_word),
      .from({(LW + 1){1'b0}}),
      .hit (d_hit),
      .pos (d_pos)
   );

   assign d_next = (idx_q << LW) | SLOT_W'(d_pos);

   // ---------------------------------------------------------------
   // control
   // ---------------------------------------------------------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         set_q      <= 1'b0;
         slot_q     <= '0;
         idx_q      <= '0;
         lvl_q      <= '0;
         resp_valid <= 1'b0;
         resp_found <= 1'b0;
         resp_slot  <= '0;
      end else begin
         resp_valid <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  slot_q <= req_slot;
                  set_q  <= req_active;
                  lvl_q  <= '0;
                  st_q   <= req_write ? ST_UPD : ST_PROBE;
               end
            end
            ST_UPD: begin
               if (lvl_q == LVLW'(LEVELS - 1)) st_q <= ST_IDLE;
               else                            lvl_q <= lvl_q + 1'b1;
            end
            ST_PROBE: begin
               if (!sel_any) begin
                  resp_valid <= 1'b1;
                  resp_found <= 1'b0;
                  resp_slot  <= '0;
                  st_q       <= ST_IDLE;
               end else if (sel_lvl == '0) begin
                  resp_valid <= 1'b1;
                  resp_found <= 1'b1;
                  resp_slot  <= sel_idx;
                  st_q       <= ST_IDLE;
               end else begin
                  lvl_q <= sel_lvl;
                  idx_q <= sel_idx;
                  st_q  <= ST_DESC;
               end
            end
            ST_DESC: begin
               idx_q <= d_next;
               if (lvl_q == LVLW'(1)) begin
                  resp_valid <= 1'b1;
                  resp_found <= 1'b1;
                  resp_slot  <= d_next;
                  st_q       <= ST_IDLE;
               end else begin
                  lvl_q <= lvl_q - 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == ST_IDLE);

   // ---------------------------------------------------------------
   // assertions
   // ---------------------------------------------------------------
   logic [LATW-1:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      lat_q <= '0;
      else if (st_q == ST_PROBE || st_q == ST_DESC)    lat_q <= lat_q + 1'b1;
      else                                             lat_q <= '0;
   end

   assert_search_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PROBE || st_q == ST_DESC) |-> (lat_q < LATW'(LEVELS)));

   assert_resp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_resp_from_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resp_valid) |-> $past(!req_ready));

   assert_desc_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DESC) |-> d_hit);

   assert_none_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_found) |-> (resp_slot == '0));
endmodule

// File: tb/sim_hb_next_slot_finder.sv
`timescale 1ns/1ps
module sim_hb_next_slot_finder;
   localparam int FANOUT = 8;
   localparam int LEVELS = 3;
   localparam int SW     = 9;
   localparam int N      = 512;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, req_ready, req_write, req_active;
   logic [SW-1:0] req_slot;
   logic          resp_valid, resp_found;
   logic [SW-1:0] resp_slot;

   always #5 clk = ~clk;

   hb_next_slot_finder #(.FANOUT(FANOUT), .LEVELS(LEVELS)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_active(req_active), .req_slot(req_slot),
      .resp_valid(resp_valid), .resp_found(resp_found), .resp_slot(resp_slot)
   );

   bit [N-1:0] model;
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic void exp_find(input int start, output bit f, output int s);
      f = 1'b0;
      s = 0;
      for (int i = 0; i < N; i++) begin
         int j;
         j = (start + i) % N;
         if (!f && model[j]) begin
            f = 1'b1;
            s = j;
         end
      end
   endfunction

   task automatic wait_ready();
      int w;
      w = 0;
      while (!req_ready && w < 50) begin
         @(negedge clk);
         w++;
      end
   endtask

   task automatic do_update(input int slot, input bit val);
      int n;
      wait_ready();
      req_valid  = 1'b1;
      req_write  = 1'b1;
      req_active = val;
      req_slot   = SW'(slot);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      check(req_ready == 1'b0, "R2 busy after update accept", int'(req_ready), 0);
      while (!req_ready && n < 20) begin
         @(negedge clk);
         n++;
      end
      check(n == LEVELS, "R3 update duration", n, LEVELS);
      model[slot] = val;
   endtask

   task automatic do_search(input int start, input string tag);
      int n;
      bit ef;
      int es;
      wait_ready();
      req_valid = 1'b1;
      req_write = 1'b0;
      req_slot  = SW'(start);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!resp_valid && n < 20) begin
         @(negedge clk);
         n++;
      end
      exp_find(start, ef, es);
      check(n >= 1 && n <= LEVELS, "R4 search latency", n, LEVELS);
      check(resp_found == ef, {tag, " found flag"}, int'(resp_found), int'(ef));
      check(int'(resp_slot) == es, {tag, " slot"}, int'(resp_slot), es);
      @(negedge clk);
      check(resp_valid == 1'b0, "R4 single-cycle strobe", int'(resp_valid), 0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd20245);
      model      = '0;
      rst_n      = 1'b0;
      req_valid  = 1'b0;
      req_write  = 1'b0;
      req_active = 1'b0;
      req_slot   = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
      check(resp_valid == 1'b0, "R1 no strobe after reset", int'(resp_valid), 0);
      do_search(0, "R1 empty map");
      do_search(300, "R6 empty map");

      // R9 / R4 / R5 directed
      do_update(5, 1'b1);
      do_search(0, "R4 leaf hit");
      do_search(5, "R9 start inclusive");
      do_search(6, "R5 wrap to lower slot");
      do_update(3, 1'b1);
      do_search(4, "R9 lower slot in word skipped");
      do_update(6, 1'b1);
      do_search(6, "R9 start equals active");
      do_update(300, 1'b1);
      do_search(7, "R4 next group");
      do_search(64, "R4 climb to top");
      // R8: clearing a neighbour keeps others visible
      do_update(6, 1'b0);
      do_search(6, "R8 neighbour cleared");
      do_update(5, 1'b0);
      do_search(4, "R8 word still holds slot 3");
      do_update(3, 1'b0);
      do_search(0, "R8 empty word skipped");
      // R3: repeated writes are idempotent
      do_update(300, 1'b1);
      do_search(300, "R3 repeat set");
      do_update(511, 1'b1);
      do_search(301, "R4 last slot");
      do_update(300, 1'b0);
      do_update(300, 1'b0);
      do_search(0, "R3 repeat clear");
      do_search(511, "R9 top slot inclusive");
      do_update(0, 1'b1);
      do_search(1, "R5 wrap to slot 0");
      do_update(0, 1'b0);
      do_update(511, 1'b0);
      do_search(200, "R6 emptied map");

      // constrained random mix
      for (int k = 0; k < 600; k++) begin
         int op;
         int slot;
         op = int'($urandom_range(0, 2));
         if ($urandom_range(0, 1) == 0) slot = int'($urandom_range(96, 127));
         else                           slot = int'($urandom_range(0, N - 1));
         if (op == 0)      do_update(slot, 1'b1);
         else if (op == 1) do_update(slot, 1'b0);
         else              do_search(slot, "R4 R5 random");
      end

      // drain everything, then the map must read empty
      for (int i = 0; i < N; i++) begin
         if (model[i]) begin
            do_update(i, 1'b0);
            if (i % 7 == 0) do_search(i, "R8 drain");
         end
      end
      do_search(0, "R6 after drain");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule